// File: doc/BRIEF.md
# Timer/Counter with Shared Scaler

An 8-bit up-counter that advances either on an instruction-cycle strobe from the core or on edges of an external clock pin. The pin is first synchronized to the block clock. The rising or falling edge is selectable. One 8-bit scaler serves two possible owners. When it belongs to the counter, it divides the counting source before the count register. When it belongs to the watchdog path, it divides a base tick from the watchdog oscillator and produces the watchdog tick output.

Software writes the count and a control byte through a plain write port and reads both back. The scaler itself is hidden. A write to the count restarts the scaler, but only when the counter owns it, and it blocks counting for two instruction strobes. A watchdog-clear strobe restarts the scaler when the watchdog path owns it. A rollover sets a sticky flag, which a dedicated clear input removes.

Top module: `tmr8_shared_scaler`

## Requirements
- R1: After reset the block is in its idle state: `cnt_o` is 0x00, `ctl_o` is 0x00, `ovf_o` is 0 and `wdt_tick_o` is 0.
- R2: A control write stores `wdata_i[5:0]` in the control byte, which `ctl_o` shows one clock later. The field layout is: bit 5 selects the source (0 internal strobe, 1 pin), bit 4 selects the edge (0 rising, 1 falling), bit 3 gives the owner (0 counter, 1 watchdog) and bits 2:0 hold the ratio code. Bits 7:6 always read 0.
- R3: With bit 5 at 0 and bit 3 at 1, `cnt_o` rises by one on the clock edge where `cyc_tick_i` is high. It does not change on other edges.
- R4: With bit 5 at 1, a pin level change of the selected polarity is recognized at the first `cyc_tick_i` that comes at least three clock edges after the change. The count then rises at the next `cyc_tick_i`. A change of the other polarity, or strobes with no pin change, leave the count unchanged.
- R5: With bit 3 at 0, the count advances once for every 2^(code+1) source events, so code 0 gives divide-by-2 and code 7 gives divide-by-256.
- R6: A count write loads `wdata_i` into `cnt_o` on the next clock edge. When bit 3 is 0, the write also restarts the scaler from zero.
- R7: After a count write, the next two `cyc_tick_i` strobes produce no count advance, however many clocks separate them from the write.
- R8: With bit 3 at 1, `wdt_tick_o` pulses for one clock after each 2^code-th `wdt_base_i` pulse, so code 0 passes every base pulse. With bit 3 at 0, `wdt_tick_o` repeats every `wdt_base_i` pulse one clock later.
- R9: `wdt_clr_i` restarts the scaler only when bit 3 is 1. When bit 3 is 0 it has no effect on the counting ratio.
- R10: A count rollover from 0xFF to 0x00 sets `ovf_o`. The flag stays set until `ovf_clr_i` is applied. If a clear and a rollover happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_tick_i | input | 1 | Instruction-cycle strobe, one clock wide |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| wdt_base_i | input | 1 | Watchdog base tick, one clock wide |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| cnt_wr_i | input | 1 | Write strobe for the count |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| wdata_i | input | 8 | Write data |
| ovf_clr_i | input | 1 | Clears the rollover flag |
| cnt_o | output | 8 | Current count |
| ctl_o | output | 8 | Control byte readback |
| ovf_o | output | 1 | Sticky rollover flag |
| wdt_tick_o | output | 1 | Scaled watchdog tick |

## Verification
The assertions take the input strobes to be synchronous to the clock and one clock wide. They also assume a count write is never issued together with a control write. Only the pin input may change freely. The stimulus drives every input half a period away from the active edge and pulses each strobe for exactly one clock. It holds the pin steady for at least three clocks before the strobe that must detect a change. All counting checks begin after a count write, so the scaler phase and the two blocked strobes are known.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       src_ext;
    logic       edge_fall;
    logic       to_wdt;
    logic [2:0] ratio;
  } ctl_t;
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  input  logic fall_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic prev_q, pend_q, lvl, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], pin_i};
  end

  assign lvl = sync_q[STAGES-1];
  // polarity folded in by xor: detect 0->1 of the adjusted level
  assign hit = (lvl ^ fall_i) & ~(prev_q ^ fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (tick_i) begin
      prev_q <= lvl;
      pend_q <= hit;
    end
  end

  assign evt_o = tick_i & pend_q;
endmodule

// File: rtl/tmr8_scaler.sv
module tmr8_scaler #(
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          to_wdt_i,
  input  logic [RW-1:0] ratio_i,
  input  logic          tmr_evt_i,
  input  logic          tmr_clr_i,
  input  logic          wdt_base_i,
  input  logic          wdt_clr_i,
  output logic          tmr_inc_o,
  output logic          wdt_tick_o
);
  localparam int SW = 2 ** RW;

  logic [SW-1:0] pre_q, mask;
  logic step, clr, full, wdt_q;

  for (genvar i = 0; i < SW; i++) begin : g_mask
    // counter owner: bits 0..code; watchdog owner: bits below code
    assign mask[i] = to_wdt_i ? ((RW+1)'(i) <  {1'b0, ratio_i})
                              : ((RW+1)'(i) <= {1'b0, ratio_i});
  end

  assign step = to_wdt_i ? wdt_base_i : tmr_evt_i;
  assign clr  = to_wdt_i ? wdt_clr_i  : tmr_clr_i;
  assign full = (pre_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (clr)  pre_q <= '0;
    else if (step) pre_q <= pre_q + SW'(1);
  end

  assign tmr_inc_o = to_wdt_i ? tmr_evt_i : (tmr_evt_i & full & ~clr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdt_q <= 1'b0;
    else         wdt_q <= to_wdt_i ? (wdt_base_i & full & ~wdt_clr_i) : wdt_base_i;
  end

  assign wdt_tick_o = wdt_q;
endmodule

// File: rtl/tmr8_count_core.sv
module tmr8_count_core #(
  parameter int CW        = 8,
  parameter int BLK_TICKS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          inc_i,
  input  logic          ovf_clr_i,
  output logic          open_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam int BW = $clog2(BLK_TICKS + 1);

  logic [BW-1:0] blk_q;
  logic [CW-1:0] cnt_q;
  logic ovf_q, ovf_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        blk_q <= '0;
    else if (wr_i)                      blk_q <= BW'(BLK_TICKS);
    else if (tick_i && blk_q != '0)     blk_q <= blk_q - BW'(1);
  end

  assign open_o = (blk_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  assign ovf_set = inc_i & ~wr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_set | (ovf_q & ~ovf_clr_i);
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr8_shared_scaler.sv
module tmr8_shared_scaler
  import tmr8_pkg::*;
#(
  parameter int RW          = 3,
  parameter int BLK_TICKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_tick_i,
  input  logic              ext_clk_i,
  input  logic              wdt_base_i,
  input  logic              wdt_clr_i,
  input  logic              cnt_wr_i,
  input  logic              ctl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic              ovf_o,
  output logic              wdt_tick_o
);
  ctl_t ctl_q;
  logic ext_evt, src_evt, gated_evt, tmr_inc, cnt_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_wr_i) ctl_q <= ctl_t'({2'b00, wdata_i[5:0]});
  end

  assign ctl_o = ctl_q;

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(cyc_tick_i),
    .pin_i (ext_clk_i),
    .fall_i(ctl_q.edge_fall),
    .evt_o (ext_evt)
  );

  assign src_evt   = ctl_q.src_ext ? ext_evt : cyc_tick_i;
  assign gated_evt = src_evt & cnt_open;

  tmr8_scaler #(.RW(RW)) u_scaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .to_wdt_i  (ctl_q.to_wdt),
    .ratio_i   (ctl_q.ratio[RW-1:0]),
    .tmr_evt_i (gated_evt),
    .tmr_clr_i (cnt_wr_i),
    .wdt_base_i(wdt_base_i),
    .wdt_clr_i (wdt_clr_i),
    .tmr_inc_o (tmr_inc),
    .wdt_tick_o(wdt_tick_o)
  );

  tmr8_count_core #(.CW(DATA_W), .BLK_TICKS(BLK_TICKS)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cyc_tick_i),
    .wr_i     (cnt_wr_i),
    .wdata_i  (wdata_i),
    .inc_i    (tmr_inc),
    .ovf_clr_i(ovf_clr_i),
    .open_o   (cnt_open),
    .cnt_o    (cnt_o),
    .ovf_o    (ovf_o)
  );
endmodule

// File: rtl/tmr8_shared_scaler_chk.sv
module tmr8_shared_scaler_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cnt_wr_i,
  input logic [7:0] wdata_i,
  input logic       ovf_clr_i,
  input logic       wdt_base_i,
  input logic [7:0] cnt_o,
  input logic       ovf_o,
  input logic       wdt_tick_o,
  input logic       open_i
);
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_o == $past(wdata_i)); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (cnt_o == $past(cnt_o) || cnt_o == 8'($past(cnt_o) + 8'd1))); // R3
  AST_BLOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_i && !cnt_wr_i) |=> $stable(cnt_o)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R10
  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> cnt_o == 8'h00); // R10
  AST_WDT_FROM_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tick_o |-> $past(wdt_base_i)); // R8
endmodule

bind tmr8_shared_scaler tmr8_shared_scaler_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_wr_i  (cnt_wr_i),
  .wdata_i   (wdata_i),
  .ovf_clr_i (ovf_clr_i),
  .wdt_base_i(wdt_base_i),
  .cnt_o     (cnt_o),
  .ovf_o     (ovf_o),
  .wdt_tick_o(wdt_tick_o),
  .open_i    (cnt_open)
);

// File: tb/sim_tmr8_shared_scaler.sv
module sim_tmr8_shared_scaler;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_tick_i = 0, ext_clk_i = 0, wdt_base_i = 0, wdt_clr_i = 0;
  logic cnt_wr_i = 0, ctl_wr_i = 0, ovf_clr_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] cnt_o, ctl_o;
  logic ovf_o, wdt_tick_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    int       kind; // 0 cnt, 1 ovf, 2 wdt tick, 3 ctl
    logic [7:0] exp;
    string    tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  tmr8_shared_scaler u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_tick_i(cyc_tick_i), .ext_clk_i(ext_clk_i),
    .wdt_base_i(wdt_base_i), .wdt_clr_i(wdt_clr_i), .cnt_wr_i(cnt_wr_i),
    .ctl_wr_i(ctl_wr_i), .wdata_i(wdata_i), .ovf_clr_i(ovf_clr_i),
    .cnt_o(cnt_o), .ctl_o(ctl_o), .ovf_o(ovf_o), .wdt_tick_o(wdt_tick_o)
  );

  task automatic expect_v(input int kind, input logic [7:0] v, input string tag);
    item_t it;
    it.kind = kind; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = cnt_o;
          1: act = {7'd0, ovf_o};
          2: act = {7'd0, wdt_tick_o};
          default: act = ctl_o;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d act=%0h exp=%0h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input logic t, input logic b, input logic wc, input logic oc);
    cyc_tick_i = t; wdt_base_i = b; wdt_clr_i = wc; ovf_clr_i = oc;
    @(negedge clk);
    cyc_tick_i = 0; wdt_base_i = 0; wdt_clr_i = 0; ovf_clr_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_wr_i = 1; wdata_i = v;
    @(negedge clk);
    cnt_wr_i = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr_i = 1; wdata_i = v;
    @(negedge clk);
    ctl_wr_i = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    expect_v(0, 8'h00, "R1 cnt"); expect_v(3, 8'h00, "R1 ctl");
    expect_v(1, 8'h00, "R1 ovf"); expect_v(2, 8'h00, "R1 wdt");
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R2 control readback, upper bits read 0
    wr_ctl(8'hFF); expect_v(3, 8'h3F, "R2 ctl upper masked");
    wr_ctl(8'h08); expect_v(3, 8'h08, "R2 ctl value");

    // R3/R6/R7 internal, no prescale
    wr_cnt(8'h10); expect_v(0, 8'h10, "R6 load");
    idle(5); ticks(1); expect_v(0, 8'h10, "R7 first strobe blocked");
    ticks(1); expect_v(0, 8'h10, "R7 second strobe blocked");
    ticks(1); expect_v(0, 8'h11, "R7 third strobe counts");
    idle(2); expect_v(0, 8'h11, "R3 no strobe no count");
    ticks(1); idle(1); ticks(2); expect_v(0, 8'h14, "R3 spaced strobes");

    // R5/R6 divide-by-4 and scaler restart on write
    wr_ctl(8'h01);
    wr_cnt(8'h20); ticks(2); ticks(3); expect_v(0, 8'h20, "R5 /4 three events");
    ticks(1); expect_v(0, 8'h21, "R5 /4 fourth event");
    ticks(2); wr_cnt(8'h40); ticks(2); ticks(3);
    expect_v(0, 8'h40, "R6 scaler cleared by write");
    ticks(1); expect_v(0, 8'h41, "R6 /4 after restart");

    // R5 divide-by-256
    wr_ctl(8'h07);
    wr_cnt(8'h00); ticks(2); ticks(255); expect_v(0, 8'h00, "R5 /256 255 events");
    ticks(1); expect_v(0, 8'h01, "R5 /256 256th event");

    // R10 overflow
    wr_ctl(8'h08);
    wr_cnt(8'hFE); ticks(2); ticks(1);
    expect_v(0, 8'hFF, "R10 at FF"); expect_v(1, 8'h00, "R10 no flag yet");
    ticks(1); expect_v(0, 8'h00, "R10 wrap"); expect_v(1, 8'h01, "R10 flag set");
    ticks(1); expect_v(1, 8'h01, "R10 sticky");
    cyc(0, 0, 0, 1); expect_v(1, 8'h00, "R10 cleared");
    wr_cnt(8'hFF); ticks(2); cyc(1, 0, 0, 1);
    expect_v(1, 8'h01, "R10 set wins over clear");
    cyc(0, 0, 0, 1); expect_v(1, 8'h00, "R10 cleared again");

    // R4 external pin, rising edge
    wr_ctl(8'h28);
    wr_cnt(8'h00); ticks(2); expect_v(0, 8'h00, "R4 quiet strobes");
    ext_clk_i = 1; idle(3); ticks(1); expect_v(0, 8'h00, "R4 edge seen no count yet");
    ticks(1); expect_v(0, 8'h01, "R4 rising counted");
    ticks(2); expect_v(0, 8'h01, "R4 held level no count");
    ext_clk_i = 0; idle(3); ticks(2); expect_v(0, 8'h01, "R4 falling ignored");
    wr_ctl(8'h38);
    ext_clk_i = 1; idle(3); ticks(2); expect_v(0, 8'h01, "R4 rising ignored when falling selected");
    ext_clk_i = 0; idle(3); ticks(1); expect_v(0, 8'h01, "R4 falling seen");
    ticks(1); expect_v(0, 8'h02, "R4 falling counted");

    // R8/R9 watchdog path, divide-by-4
    wr_ctl(8'h0A);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0); expect_v(2, 8'h00, "R8 base 1");
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); expect_v(2, 8'h00, "R8 base 3");
    cyc(0, 1, 0, 0); expect_v(2, 8'h01, "R8 tick on base 4");
    idle(1); expect_v(2, 8'h00, "R8 tick one clock");
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    expect_v(2, 8'h00, "R9 clear restarts watchdog scaler");
    cyc(0, 1, 0, 0); expect_v(2, 8'h01, "R9 tick after restart");
    wr_ctl(8'h08);
    cyc(0, 1, 0, 0); expect_v(2, 8'h01, "R8 code 0 passes every base");
    idle(1); expect_v(2, 8'h00, "R8 code 0 pulse ends");
    wr_ctl(8'h00);
    cyc(0, 1, 0, 0); expect_v(2, 8'h01, "R8 unscaled when counter owns scaler");

    // R9 watchdog clear ignored while counter owns scaler (/2)
    wr_cnt(8'h50); ticks(2); ticks(1); expect_v(0, 8'h50, "R9 /2 first event");
    cyc(0, 0, 1, 0); ticks(1); expect_v(0, 8'h51, "R9 clear had no effect");

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule